// File: doc/BRIEF.md
# Oldest-First Memory Port Collision Arbiter

This block sits beside a loop pipeline that lets a new iteration begin the moment its input data is ready, instead of waiting for the next interval boundary. Because of these unaligned starts, operations from different iterations still in flight can ask for the two shared memory read/write ports in the same cycle. The arbiter finds such collisions in that cycle and hands the ports out by iteration age. The oldest requester gets port 0, the next oldest gets port 1, and every other requester is told to stall and try again.

The pipeline has a fixed number of iteration slots. A pulse on a slot's start input marks a new iteration in that slot. The arbiter stamps it with a modular age tag, so older iterations can still be ranked correctly after the tag counter wraps. A stall reaches the losing slot and every younger slot. It never reaches an older one, so older iterations keep draining while younger ones wait. A deferred request that is held high is granted in the first later cycle in which a port is left for it.

Top module: `oldest_first_port_arb`

## Requirements
- R1: After reset no slot is active: no grant, no stall and no collision are reported until a slot is started.
- R2: A start pulse on slot s makes s active from the next cycle and gives it an age younger than every active iteration. When several slots start in the same cycle, the lower slot index counts as older.
- R3: A request from a slot that is not active is ignored. It draws no grant and no stall, and it is not counted toward a collision.
- R4: Port 0 is granted to the oldest active requester and port 1 to the second oldest. gnt_vld_o[p] is high exactly when port p is granted. Grant bit p*NUM_SLOTS+s means port p goes to slot s.
- R5: At most one grant bit is high per port, and no slot holds more than one port in a cycle.
- R6: collision_o is high in exactly those cycles in which more than two active slots request.
- R7: stall_o[s] is high when active slot s loses its own request, or when any active slot older than s loses. A loss by a younger slot never stalls s.
- R8: A deferred request kept high is granted in the first later cycle in which fewer than two older active slots request, with no added wait.
- R9: Age order stays correct across wraparound of the AGE_W-bit tag counter, as long as the in-flight iterations span fewer than 2^(AGE_W-1) starts.
- R10: A done pulse on slot s makes s inactive from the next cycle. If start and done hit the same slot in the same cycle, the start wins.
- R11: Starting a slot that is already active re-stamps it as the youngest iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | NUM_SLOTS | New iteration begins in slot |
| done_i | input | NUM_SLOTS | Iteration in slot has retired |
| req_i | input | NUM_SLOTS | Slot wants a memory port this cycle |
| gnt_o | output | 2*NUM_SLOTS | Port-major grant matrix, bit p*NUM_SLOTS+s |
| gnt_vld_o | output | 2 | Port p is granted this cycle |
| stall_o | output | NUM_SLOTS | Slot must hold this cycle |
| collision_o | output | 1 | More active requests than ports |

## Verification
The directed patterns cover several cases. One starts two slots in the same cycle, which tells an index-ordered tie-break apart from an arbitrary one. A four-way request then shows whether both ports and the stall chain follow age or slot index. Dropping the oldest requests in the next cycle separates immediate retry from any waiting for alignment. Re-stamping an active slot and clashing start with done test the age bookkeeping. A rotating restart sequence pushes the tag counter through several wraps. A long random run with a fixed seed mixes starts, retirements and requests, limited to the legal age window, and catches rank errors that only appear under irregular age patterns.

// File: rtl/ofpa_pkg.sv
package ofpa_pkg;
  localparam int unsigned NUM_PORTS = 2;

  // a older than b under modular tags of width w
  function automatic logic is_older(input logic [31:0] a, input logic [31:0] b,
                                    input int unsigned w);
    logic [31:0] diff;
    diff = a - b;
    return diff[w-1];
  endfunction
endpackage

// File: rtl/ofpa_age_track.sv
module ofpa_age_track #(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned AGE_W     = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SLOTS-1:0]       start_i,
  input  logic [NUM_SLOTS-1:0]       done_i,
  output logic [NUM_SLOTS-1:0]       active_o,
  output logic [NUM_SLOTS*AGE_W-1:0] age_o
);
  logic [AGE_W-1:0] next_age_q;
  logic [AGE_W-1:0] offs [NUM_SLOTS];
  logic [AGE_W-1:0] n_start;

  always_comb begin
    n_start = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      offs[s] = n_start;
      n_start = n_start + AGE_W'(start_i[s]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_age_q <= '0;
      active_o   <= '0;
      age_o      <= '0;
    end else begin
      next_age_q <= next_age_q + n_start;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (start_i[s]) begin
          active_o[s]               <= 1'b1;
          age_o[s*AGE_W +: AGE_W]   <= next_age_q + offs[s];
        end else if (done_i[s]) begin
          active_o[s] <= 1'b0;
        end
      end
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    AST_START_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i[s] |=> active_o[s]); // R2
    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i[s] && !start_i[s]) |=> !active_o[s]); // R10
  end
endmodule

// File: rtl/ofpa_rank.sv
module ofpa_rank
  import ofpa_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned AGE_W     = 4
) (
  input  logic [NUM_SLOTS-1:0]           active_i,
  input  logic [NUM_SLOTS-1:0]           req_i,
  input  logic [NUM_SLOTS*AGE_W-1:0]     age_i,
  output logic [NUM_PORTS*NUM_SLOTS-1:0] gnt_o,
  output logic [NUM_SLOTS*NUM_SLOTS-1:0] older_o
);
  localparam int unsigned RW = $clog2(NUM_SLOTS + 1);
  logic [RW-1:0] rank [NUM_SLOTS];

  // older_o[s*NUM_SLOTS+t]: active slot t is older than active slot s
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int t = 0; t < NUM_SLOTS; t++) begin
        older_o[s*NUM_SLOTS+t] = (s != t) && active_i[s] && active_i[t] &&
          is_older(32'(age_i[t*AGE_W +: AGE_W]), 32'(age_i[s*AGE_W +: AGE_W]), AGE_W);
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      rank[s] = '0;
      for (int t = 0; t < NUM_SLOTS; t++)
        rank[s] = rank[s] + RW'(req_i[t] && older_o[s*NUM_SLOTS+t]);
    end
    for (int p = 0; p < NUM_PORTS; p++)
      for (int s = 0; s < NUM_SLOTS; s++)
        gnt_o[p*NUM_SLOTS+s] = req_i[s] && (rank[s] == RW'(p));
  end
endmodule

// File: rtl/ofpa_stall.sv
module ofpa_stall
  import ofpa_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4
) (
  input  logic [NUM_SLOTS-1:0]           active_i,
  input  logic [NUM_SLOTS-1:0]           req_i,
  input  logic [NUM_PORTS*NUM_SLOTS-1:0] gnt_i,
  input  logic [NUM_SLOTS*NUM_SLOTS-1:0] older_i,
  output logic [NUM_SLOTS-1:0]           stall_o
);
  logic [NUM_SLOTS-1:0] won, lost;

  always_comb begin
    won = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      won = won | gnt_i[p*NUM_SLOTS +: NUM_SLOTS];
    lost = req_i & ~won;
    for (int s = 0; s < NUM_SLOTS; s++)
      stall_o[s] = active_i[s] &&
                   (lost[s] || |(older_i[s*NUM_SLOTS +: NUM_SLOTS] & lost));
  end
endmodule

// File: rtl/oldest_first_port_arb.sv
module oldest_first_port_arb
  import ofpa_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned AGE_W     = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SLOTS-1:0]           start_i,
  input  logic [NUM_SLOTS-1:0]           done_i,
  input  logic [NUM_SLOTS-1:0]           req_i,
  output logic [NUM_PORTS*NUM_SLOTS-1:0] gnt_o,
  output logic [NUM_PORTS-1:0]           gnt_vld_o,
  output logic [NUM_SLOTS-1:0]           stall_o,
  output logic                           collision_o
);
  localparam int unsigned CW = $clog2(NUM_SLOTS + 1);

  logic [NUM_SLOTS-1:0]           active;
  logic [NUM_SLOTS*AGE_W-1:0]     age;
  logic [NUM_SLOTS-1:0]           eff_req;
  logic [NUM_SLOTS*NUM_SLOTS-1:0] older;
  logic [CW-1:0]                  n_req;

  ofpa_age_track #(.NUM_SLOTS(NUM_SLOTS), .AGE_W(AGE_W)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .done_i(done_i),
    .active_o(active), .age_o(age)
  );

  assign eff_req = req_i & active;

  ofpa_rank #(.NUM_SLOTS(NUM_SLOTS), .AGE_W(AGE_W)) u_rank (
    .active_i(active), .req_i(eff_req), .age_i(age),
    .gnt_o(gnt_o), .older_o(older)
  );

  ofpa_stall #(.NUM_SLOTS(NUM_SLOTS)) u_stall (
    .active_i(active), .req_i(eff_req), .gnt_i(gnt_o),
    .older_i(older), .stall_o(stall_o)
  );

  always_comb begin
    n_req = '0;
    for (int s = 0; s < NUM_SLOTS; s++) n_req = n_req + CW'(eff_req[s]);
    collision_o = n_req > CW'(NUM_PORTS);
    for (int p = 0; p < NUM_PORTS; p++)
      gnt_vld_o[p] = |gnt_o[p*NUM_SLOTS +: NUM_SLOTS];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port_chk
    AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(gnt_o[p*NUM_SLOTS +: NUM_SLOTS])); // R5
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
    AST_ONE_PORT_PER_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({gnt_o[NUM_SLOTS+s], gnt_o[s]}) <= 1); // R5
    AST_GNT_NEEDS_ACTIVE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[s] || gnt_o[NUM_SLOTS+s]) |-> (req_i[s] && active[s])); // R3
    AST_OLDEST_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[s] |-> !stall_o[s]); // R7
  end

  AST_COLLIDE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collision_o |-> (&gnt_vld_o && |stall_o)); // R6
  AST_NO_REQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_req == '0) |-> (gnt_vld_o == '0 && stall_o == '0)); // R3
endmodule

// File: tb/tb_oldest_first_port_arb.sv
module tb_oldest_first_port_arb;
  localparam int NS = 4;
  localparam int AW = 4;
  localparam int NP = 2;
  localparam int HALF = 1 << (AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] start = '0, done = '0, req = '0;
  logic [NP*NS-1:0] gnt;
  logic [NP-1:0] gnt_vld;
  logic [NS-1:0] stall;
  logic collision;

  int checks = 0;
  int errors = 0;
  bit act [NS];
  int seq [NS];
  int nseq = 0;

  always #4 clk = ~clk;

  oldest_first_port_arb #(.NUM_SLOTS(NS), .AGE_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .done_i(done), .req_i(req),
    .gnt_o(gnt), .gnt_vld_o(gnt_vld), .stall_o(stall), .collision_o(collision)
  );

  task automatic check_now(input string tag);
    logic [NP*NS-1:0] eg;
    logic [NP-1:0] ev;
    logic [NS-1:0] es, lost;
    logic ec;
    int rk [NS];
    int n;
    eg = '0; ev = '0; es = '0; lost = '0; n = 0;
    for (int s = 0; s < NS; s++) begin
      rk[s] = 0;
      if (act[s] && req[s]) begin
        n++;
        for (int t = 0; t < NS; t++)
          if (t != s && act[t] && req[t] && seq[t] < seq[s]) rk[s]++;
        if (rk[s] < NP) begin eg[rk[s]*NS+s] = 1'b1; ev[rk[s]] = 1'b1; end
        else lost[s] = 1'b1;
      end
    end
    for (int s = 0; s < NS; s++)
      if (act[s]) begin
        es[s] = lost[s];
        for (int t = 0; t < NS; t++)
          if (act[t] && lost[t] && seq[t] < seq[s]) es[s] = 1'b1;
      end
    ec = n > NP;
    checks += 4;
    if (gnt !== eg) begin errors++;
      $display("FAIL %s R4 grant act=%h exp=%h", tag, gnt, eg); end
    if (gnt_vld !== ev) begin errors++;
      $display("FAIL %s R4 port valid act=%b exp=%b", tag, gnt_vld, ev); end
    if (stall !== es) begin errors++;
      $display("FAIL %s R7 stall act=%b exp=%b", tag, stall, es); end
    if (collision !== ec) begin errors++;
      $display("FAIL %s R6 collision act=%b exp=%b", tag, collision, ec); end
  endtask

  task automatic step(input logic [NS-1:0] st, input logic [NS-1:0] dn,
                      input logic [NS-1:0] rq, input string tag);
    @(negedge clk);
    start = st; done = dn; req = rq;
    #2;
    check_now(tag);
    for (int s = 0; s < NS; s++) begin
      if (st[s]) begin act[s] = 1'b1; seq[s] = nseq; nseq++; end
      else if (dn[s]) act[s] = 1'b0;
    end
  endtask

  // start set that keeps the in-flight span inside the legal age window
  function automatic logic [NS-1:0] legal_start(input logic [NS-1:0] st,
                                                input logic [NS-1:0] dn);
    int lo, hi, k;
    lo = 32'h7fffffff; hi = -1; k = nseq;
    for (int s = 0; s < NS; s++) begin
      if (st[s]) begin if (k > hi) hi = k; if (k < lo) lo = k; k++; end
      else if (act[s] && !dn[s]) begin
        if (seq[s] < lo) lo = seq[s];
        if (seq[s] > hi) hi = seq[s];
      end
    end
    return (hi - lo >= HALF) ? '0 : st;
  endfunction

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] st, dn, rq;
    for (int s = 0; s < NS; s++) begin act[s] = 1'b0; seq[s] = 0; end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 and R3: nothing active, all requests ignored
    step('0, '0, 4'b1111, "R1");
    step('0, '0, 4'b1111, "R3");
    // R2: same-cycle starts, slot 0 older than slot 2
    step(4'b0101, '0, '0, "R2");
    step('0, '0, 4'b0101, "R2");
    // R3: inactive slot 3 request alongside active ones
    step(4'b1000, '0, 4'b1000, "R3");
    step(4'b0010, '0, '0, "R2");
    // R6: four-way collision, order 0,2,3,1
    step('0, '0, 4'b1111, "R6");
    // R8: oldest two drop, deferred ones granted at once
    step('0, '0, 4'b1010, "R8");
    step('0, '0, 4'b1011, "R7");
    // R11: restart active slot 0, becomes youngest
    step(4'b0001, '0, '0, "R11");
    step('0, '0, 4'b1111, "R11");
    // R10: start and done collide on slot 2; done on slot 3
    step(4'b0100, 4'b1100, '0, "R10");
    step('0, '0, 4'b1111, "R10");
    // R9: rotating restarts wrap the tag counter several times
    for (int i = 0; i < 40; i++) begin
      st = '0; st[i % NS] = 1'b1;
      step(st, '0, 4'b1111, "R9");
    end
    // random mix, constrained to the legal age window
    for (int i = 0; i < 4000; i++) begin
      st = 4'($urandom) & 4'($urandom);
      dn = 4'($urandom) & 4'($urandom);
      rq = 4'($urandom) | 4'($urandom);
      st = legal_start(st, dn);
      step(st, dn, rq, "R4/R5/R7/R9");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule